// File: doc/BRIEF.md
# Frame Phase Sequencer with Peripheral Power Gating

This block is the frame-level controller of a global-shutter image sensor in which every pixel carries its own converter. A frame is a fixed walk through four phases: idle, exposure, conversion and transmission. The time-to-saturation measurement runs during exposure, and the two linear conversions run in the short global conversion window that follows. The controller steps through the phases and drives one power enable for each shared peripheral block. The conversion group is the reference generator, the ramp generator, the conversion digital logic and the clock multiplier. The output serializer stands alone. Each block is powered only around the phase that needs it.

Each enable rises a programmable number of settle cycles before its phase begins, and it falls the cycle that phase ends. The lengths of exposure, conversion and transmission, and both settle counts, are cycle counts. They are captured when a frame starts. A frame is started by a trigger pulse. In periodic mode, later frames start when a frame-period timer expires. A stop request ends periodic operation only at the idle boundary. A trigger that arrives during a frame is dropped and recorded in a sticky overrun flag.

Top module: `frame_phase_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), every enable output is low, `tts_active_o` is low and `overrun_o` is low.
- R2: A trigger sampled while idle starts a frame on the next clock. The phase code then runs 1 (exposure), 2 (conversion), 3 (transmission) and back to 0. The three phases last `exp_len_i`, `conv_len_i` and `xmit_len_i` cycles, and a length of 0 counts as 1.
- R3: `tts_active_o` is high in exactly the cycles where `phase_o` is 1.
- R4: The four conversion-group enables are high in every conversion cycle. They are also high in the last `settle_conv_i` cycles of exposure, or in the whole exposure when that count is not smaller than the exposure length. They are low in all other cycles.
- R5: `ser_en_o` is high in every transmission cycle. It is also high in the last `settle_xmit_i` cycles of conversion, or in the whole conversion when that count is not smaller than the conversion length. It is low in all other cycles.
- R6: While `phase_o` is 0, all five enable outputs are low.
- R7: Lengths and settle counts are sampled only when a frame starts. Changing them during a frame has no effect on that frame.
- R8: A frame started by a trigger with `periodic_i` high arms periodic mode. While armed, a new frame starts `frame_period_i` cycles after the previous start, or on the first idle cycle if that time has already passed.
- R9: A trigger sampled while `phase_o` is not 0 does not alter the running frame and starts no extra frame. It sets `overrun_o`, which stays high until reset.
- R10: A `stop_req_i` pulse during a frame lets that frame run to the end of transmission. It then disarms periodic mode at the next idle cycle, so no further frame starts.
- R11: There is always at least one idle cycle between the end of transmission and the next exposure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Frame trigger pulse |
| periodic_i | input | 1 | Arm periodic restart when the trigger starts a frame |
| stop_req_i | input | 1 | Request to leave periodic mode at the next idle boundary |
| exp_len_i | input | CNT_W | Exposure length in cycles |
| conv_len_i | input | CNT_W | Conversion length in cycles |
| xmit_len_i | input | CNT_W | Transmission length in cycles |
| settle_conv_i | input | CNT_W | Lead cycles for the conversion-group enables |
| settle_xmit_i | input | CNT_W | Lead cycles for the serializer enable |
| frame_period_i | input | PER_W | Start-to-start frame period in cycles |
| phase_o | output | 2 | Phase code: 0 idle, 1 exposure, 2 conversion, 3 transmission |
| tts_active_o | output | 1 | Time-to-saturation window (exposure) |
| ref_en_o | output | 1 | Reference generator power enable |
| ramp_en_o | output | 1 | Ramp generator power enable |
| cdig_en_o | output | 1 | Conversion digital logic power enable |
| cmul_en_o | output | 1 | Clock multiplier power enable |
| ser_en_o | output | 1 | Output serializer power enable |
| overrun_o | output | 1 | Sticky flag for a trigger that arrived during a frame |

## Verification
Every output comes from a flop. A trigger sampled at one rising edge therefore shows up as phase 1 and as the first-cycle enable values right after that edge. Each later phase change appears one edge after the last counted cycle of the previous phase.

The bench drives inputs and samples outputs on falling edges. It counts the cycles spent in each phase and the cycles in which each enable is high, then compares them with lengths and settle leads it computes from the programmed values. Frame intervals are measured between idle-to-exposure transitions on a free-running edge counter. A period is expected to give exactly `frame_period_i` edges, or the frame length plus one edge when the frame is longer than the period.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPOSE = 2'd1,
        PH_CONV   = 2'd2,
        PH_XMIT   = 2'd3
    } phase_e;

    localparam int NUM_BLK  = 5;
    localparam int BLK_REF  = 0;
    localparam int BLK_RAMP = 1;
    localparam int BLK_CDIG = 2;
    localparam int BLK_CMUL = 3;
    localparam int BLK_SER  = 4;

    // Phase in which a peripheral block does its work
    function automatic phase_e blk_phase(input int blk);
        return (blk == BLK_SER) ? PH_XMIT : PH_CONV;
    endfunction

    // Phase whose tail carries the settle lead for a given working phase
    function automatic phase_e lead_phase(input phase_e ph);
        case (ph)
            PH_CONV: return PH_EXPOSE;
            PH_XMIT: return PH_CONV;
            PH_EXPOSE: return PH_IDLE;
            default: return PH_XMIT;
        endcase
    endfunction

endpackage

// File: rtl/fpc_period_timer.sv
module fpc_period_timer #(
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PER_W-1:0] period_i,
    output logic             expired_o
);

    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (period_i == '0) ? '0 : period_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fpc_gate_map.sv
module fpc_gate_map
    import fpc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int N_BLK   = NUM_BLK
) (
    input  phase_e           phase_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] settle_conv_i,
    input  logic [CNT_W-1:0] settle_xmit_i,
    output logic [N_BLK-1:0] en_o
);

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        localparam phase_e USE  = blk_phase(b);
        localparam phase_e LEAD = lead_phase(USE);
        logic [CNT_W-1:0] lead_cyc;
        assign lead_cyc = (USE == PH_XMIT) ? settle_xmit_i : settle_conv_i;
        // cnt_i holds the cycles left in the current phase after this one
        assign en_o[b] = (phase_i == USE) ||
                         ((phase_i == LEAD) && (cnt_i < lead_cyc));
    end

endmodule

// File: rtl/frame_phase_seq.sv
module frame_phase_seq
    import fpc_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             periodic_i,
    input  logic             stop_req_i,
    input  logic [CNT_W-1:0] exp_len_i,
    input  logic [CNT_W-1:0] conv_len_i,
    input  logic [CNT_W-1:0] xmit_len_i,
    input  logic [CNT_W-1:0] settle_conv_i,
    input  logic [CNT_W-1:0] settle_xmit_i,
    input  logic [PER_W-1:0] frame_period_i,
    output logic [1:0]       phase_o,
    output logic             tts_active_o,
    output logic             ref_en_o,
    output logic             ramp_en_o,
    output logic             cdig_en_o,
    output logic             cmul_en_o,
    output logic             ser_en_o,
    output logic             overrun_o
);

    typedef struct packed {
        logic [CNT_W-1:0] exp_len;
        logic [CNT_W-1:0] conv_len;
        logic [CNT_W-1:0] xmit_len;
        logic [CNT_W-1:0] settle_conv;
        logic [CNT_W-1:0] settle_xmit;
    } cfg_t;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        cfg_t             cfg;
        logic             armed;
        logic             stop_pend;
        logic             overrun;
    } seq_t;

    seq_t               s_d, s_q;
    logic [NUM_BLK-1:0] en_d, en_q;
    logic               start;
    logic               stop_now;
    logic               per_expired;

    function automatic logic [CNT_W-1:0] len_to_cnt(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    fpc_period_timer #(
        .PER_W (PER_W)
    ) period_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start),
        .period_i  (frame_period_i),
        .expired_o (per_expired)
    );

    always_comb begin
        s_d      = s_q;
        start    = 1'b0;
        stop_now = s_q.stop_pend | stop_req_i;

        if (s_q.phase == PH_IDLE) begin
            if (stop_now) begin
                s_d.armed     = 1'b0;
                s_d.stop_pend = 1'b0;
            end
            start = trig_i | (s_q.armed & per_expired & ~stop_now);
            if (start) begin
                s_d.phase           = PH_EXPOSE;
                s_d.cfg.exp_len     = exp_len_i;
                s_d.cfg.conv_len    = conv_len_i;
                s_d.cfg.xmit_len    = xmit_len_i;
                s_d.cfg.settle_conv = settle_conv_i;
                s_d.cfg.settle_xmit = settle_xmit_i;
                s_d.cnt             = len_to_cnt(exp_len_i);
                if (trig_i) s_d.armed = periodic_i;
            end
        end else begin
            if (stop_req_i) s_d.stop_pend = 1'b1;
            if (trig_i)     s_d.overrun   = 1'b1;
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                case (s_q.phase)
                    PH_EXPOSE: begin
                        s_d.phase = PH_CONV;
                        s_d.cnt   = len_to_cnt(s_q.cfg.conv_len);
                    end
                    PH_CONV: begin
                        s_d.phase = PH_XMIT;
                        s_d.cnt   = len_to_cnt(s_q.cfg.xmit_len);
                    end
                    default: begin
                        s_d.phase = PH_IDLE;
                        s_d.cnt   = '0;
                    end
                endcase
            end
        end
    end

    // Enables are decoded from the next state and registered, so each
    // power enable leaves the block straight from a flop.
    fpc_gate_map #(
        .CNT_W (CNT_W),
        .N_BLK (NUM_BLK)
    ) gate_i (
        .phase_i       (s_d.phase),
        .cnt_i         (s_d.cnt),
        .settle_conv_i (s_d.cfg.settle_conv),
        .settle_xmit_i (s_d.cfg.settle_xmit),
        .en_o          (en_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q  <= '0;
            en_q <= '0;
        end else begin
            s_q  <= s_d;
            en_q <= en_d;
        end
    end

    assign phase_o      = s_q.phase;
    assign tts_active_o = (s_q.phase == PH_EXPOSE);
    assign ref_en_o     = en_q[BLK_REF];
    assign ramp_en_o    = en_q[BLK_RAMP];
    assign cdig_en_o    = en_q[BLK_CDIG];
    assign cmul_en_o    = en_q[BLK_CMUL];
    assign ser_en_o     = en_q[BLK_SER];
    assign overrun_o    = s_q.overrun;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic [1:0] phase_o,
    input logic       ref_en_o,
    input logic       ramp_en_o,
    input logic       cdig_en_o,
    input logic       cmul_en_o,
    input logic       ser_en_o,
    input logic       overrun_o
);

    logic conv_all, conv_any;
    assign conv_all = ref_en_o & ramp_en_o & cdig_en_o & cmul_en_o;
    assign conv_any = ref_en_o | ramp_en_o | cdig_en_o | cmul_en_o;

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> (phase_o == 2'($past(phase_o) + 2'd1)));

    assert_conv_group_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |-> conv_all);

    assert_conv_group_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |-> !conv_any);

    assert_ser_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |-> ser_en_o);

    assert_ser_off_expose_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1) |-> !ser_en_o);

    assert_idle_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |-> !(conv_any | ser_en_o));

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && phase_o != 2'd0) |=> overrun_o);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun_o) |-> overrun_o);

endmodule

bind frame_phase_seq fpc_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .phase_o   (phase_o),
    .ref_en_o  (ref_en_o),
    .ramp_en_o (ramp_en_o),
    .cdig_en_o (cdig_en_o),
    .cmul_en_o (cmul_en_o),
    .ser_en_o  (ser_en_o),
    .overrun_o (overrun_o)
);

// File: tb/frame_phase_seq_tb_top.sv
module frame_phase_seq_tb_top;

    localparam int CNT_W = 12;
    localparam int PER_W = 20;
    localparam int NVEC  = 6;
    // exp, conv, xmit, settle_conv, settle_xmit
    localparam int VEC [NVEC][5] = '{
        '{ 8, 4, 3,  2, 1},
        '{ 3, 5, 2,  6, 0},
        '{ 0, 1, 0,  0, 3},
        '{10, 6, 4,  0, 6},
        '{12, 2, 7, 12, 2},
        '{ 1, 3, 1,  1, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_i = 1'b0;
    logic             periodic_i = 1'b0;
    logic             stop_req_i = 1'b0;
    logic [CNT_W-1:0] exp_len_i = '0;
    logic [CNT_W-1:0] conv_len_i = '0;
    logic [CNT_W-1:0] xmit_len_i = '0;
    logic [CNT_W-1:0] settle_conv_i = '0;
    logic [CNT_W-1:0] settle_xmit_i = '0;
    logic [PER_W-1:0] frame_period_i = '0;
    logic [1:0]       phase_o;
    logic             tts_active_o, ref_en_o, ramp_en_o, cdig_en_o, cmul_en_o;
    logic             ser_en_o, overrun_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    frame_phase_seq #(.CNT_W(CNT_W), .PER_W(PER_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .periodic_i(periodic_i),
        .stop_req_i(stop_req_i), .exp_len_i(exp_len_i), .conv_len_i(conv_len_i),
        .xmit_len_i(xmit_len_i), .settle_conv_i(settle_conv_i),
        .settle_xmit_i(settle_xmit_i), .frame_period_i(frame_period_i),
        .phase_o(phase_o), .tts_active_o(tts_active_o), .ref_en_o(ref_en_o),
        .ramp_en_o(ramp_en_o), .cdig_en_o(cdig_en_o), .cmul_en_o(cmul_en_o),
        .ser_en_o(ser_en_o), .overrun_o(overrun_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion before it", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int eff(input int len);
        return (len == 0) ? 1 : len;
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic set_cfg(input int e, input int c, input int t, input int sc, input int st);
        exp_len_i     = CNT_W'(e);
        conv_len_i    = CNT_W'(c);
        xmit_len_i    = CNT_W'(t);
        settle_conv_i = CNT_W'(sc);
        settle_xmit_i = CNT_W'(st);
    endtask

    // Leaves the caller on the falling edge of the first exposure cycle
    task automatic start_frame();
        @(negedge clk) trig_i = 1'b1;
        @(negedge clk) trig_i = 1'b0;
    endtask

    // Tallies the rest of a frame from the current falling edge until idle
    task automatic watch_frame(output int ne, output int nc, output int nt,
                               output int pc, output int ps, output int bad_t,
                               output int bad_e, output int idle_en);
        logic grp;
        ne = 0; nc = 0; nt = 0; pc = 0; ps = 0; bad_t = 0; bad_e = 0; idle_en = 0;
        for (int i = 0; i < 5000 && phase_o != 2'd0; i++) begin
            grp = ref_en_o;
            if ({ramp_en_o, cdig_en_o, cmul_en_o} != {3{grp}}) bad_e++;
            if (tts_active_o != (phase_o == 2'd1)) bad_t++;
            case (phase_o)
                2'd1: begin ne++; if (grp) pc++; if (ser_en_o) bad_e++; end
                2'd2: begin nc++; if (ser_en_o) ps++; if (!grp) bad_e++; end
                default: begin nt++; if (grp || !ser_en_o) bad_e++; end
            endcase
            @(negedge clk);
        end
        idle_en = int'(ref_en_o) + int'(ramp_en_o) + int'(cdig_en_o)
                + int'(cmul_en_o) + int'(ser_en_o) + int'(tts_active_o);
    endtask

    task automatic wait_start(output int at);
        logic [1:0] prev;
        prev = phase_o;
        at = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (prev == 2'd0 && phase_o == 2'd1) begin
                at = cyc;
                break;
            end
            prev = phase_o;
        end
    endtask

    initial begin
        int ne, nc, nt, pc, ps, bt, be, ie;
        int t1, t2, t3, t4, t5, busy;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 phase", int'(phase_o), 0);
        check("R1 enables", int'({ref_en_o, ramp_en_o, cdig_en_o, cmul_en_o, ser_en_o, tts_active_o}), 0);
        check("R1 overrun", int'(overrun_o), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: single-shot frames
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            start_frame();
            watch_frame(ne, nc, nt, pc, ps, bt, be, ie);
            check("R2 exposure length", ne, eff(VEC[v][0]));
            check("R2 conversion length", nc, eff(VEC[v][1]));
            check("R2 transmission length", nt, eff(VEC[v][2]));
            check("R4 conversion-group lead", pc, min2(VEC[v][3], eff(VEC[v][0])));
            check("R5 serializer lead", ps, min2(VEC[v][4], eff(VEC[v][1])));
            check("R3 tts window mismatches", bt, 0);
            check("R4 R5 enable mismatches", be, 0);
            check("R6 idle enables", ie, 0);
            repeat (3) @(negedge clk);
        end

        // R7: configuration change during a frame has no effect
        set_cfg(6, 3, 2, 2, 1);
        start_frame();
        set_cfg(40, 20, 30, 9, 9);
        watch_frame(ne, nc, nt, pc, ps, bt, be, ie);
        check("R7 exposure length", ne, 6);
        check("R7 conversion length", nc, 3);
        check("R7 transmission length", nt, 2);
        check("R7 conversion-group lead", pc, 2);
        check("R7 serializer lead", ps, 1);
        repeat (3) @(negedge clk);

        // R8 / R11: periodic restart
        set_cfg(5, 4, 3, 1, 1);
        frame_period_i = PER_W'(40);
        periodic_i = 1'b1;
        start_frame();
        t1 = cyc;
        periodic_i = 1'b0;
        wait_start(t2);
        check("R8 period interval", t2 - t1, 40);
        wait_start(t3);
        check("R8 period interval", t3 - t2, 40);
        frame_period_i = PER_W'(8);
        wait_start(t4);
        check("R8 period interval", t4 - t3, 40);
        wait_start(t5);
        check("R11 overlong frame interval", t5 - t4, 13);

        // R10: stop during a frame, frame completes, then no restart
        @(negedge clk) stop_req_i = 1'b1;
        @(negedge clk) stop_req_i = 1'b0;
        watch_frame(ne, nc, nt, pc, ps, bt, be, ie);
        check("R10 frame finishes transmission", nt, 3);
        busy = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (phase_o != 2'd0) busy++;
        end
        check("R10 no restart after stop", busy, 0);

        // R9: trigger during a frame
        check("R9 overrun before", int'(overrun_o), 0);
        set_cfg(6, 3, 2, 0, 0);
        start_frame();
        trig_i = 1'b1;
        @(negedge clk) trig_i = 1'b0;
        check("R9 overrun set", int'(overrun_o), 1);
        watch_frame(ne, nc, nt, pc, ps, bt, be, ie);
        check("R9 exposure unchanged", ne, 5);
        check("R9 conversion unchanged", nc, 3);
        busy = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (phase_o != 2'd0) busy++;
        end
        check("R9 no extra frame", busy, 0);
        check("R9 overrun sticky", int'(overrun_o), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule